// File: doc/BRIEF.md
# Pipelined 48-bit LCG Batch Engine

This engine takes a batch of 32-bit seed words held in a wide memory and replaces each one with a scrambled result. Each seed becomes a 48-bit linear congruential state and is advanced a fixed number of times. The top 31 bits of the final state are then written back to the same location.

The step chain is unrolled into one register stage per step. Each lane can therefore take a new seed on every cycle, and several lanes run side by side across a single wide memory word. Software places the seeds in memory and pulses `start`. The engine reads every word of the batch, in ascending address order, one word per cycle. Read responses come back in order with a valid flag and may contain gaps. Each returned word leaves the pipeline after a fixed latency as a write with byte enables. When the last write has been issued, the engine raises `done` for one cycle.

Top module: `lcg_batch_engine`

## Requirements
- R1: A 32-bit seed s is loaded as the 48-bit state {s, 16'h330E}. A seed of zero therefore starts from the state 0x330E.
- R2: One step maps the state x to (0x5DEECE66D * x + 0xB) mod 2^48.
- R3: Each result is exactly N_STEPS steps (default 5) from its seed. It is written as {1'b0, state[47:17]}, so bit 31 is always clear.
- R4: Item i lives in memory word i / LANES, at bits [32*(i%LANES)+31 : 32*(i%LANES)]. Its result is written to the same word address and the same bit slice.
- R5: The cycle after an accepted `start`, `mem_rd_valid` rises. It stays high for N_WORDS = ceil(N_ITEMS/LANES) consecutive cycles, with addresses 0, 1, ..., N_WORDS-1.
- R6: Read responses may arrive back to back or with gaps. If a response is presented in cycle c, its write is presented in cycle c + N_STEPS + 1, so every lane accepts one new seed per cycle.
- R7: `mem_wr_be` carries one bit per byte, and bits 4l to 4l+3 belong to lane l. These bits are 1 only when word_addr*LANES + l < N_ITEMS. Memory words past the end of the batch are left unchanged.
- R8: `done` is high for exactly one cycle, the cycle after the batch's last write, and it is raised once per run.
- R9: A `start` pulse while a batch is in progress is ignored. It causes no extra reads, writes or `done` pulses.
- R10: After reset `mem_rd_valid`, `mem_wr_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin processing the batch (ignored while busy) |
| done | output | 1 | One-cycle pulse after the final write |
| mem_rd_valid | output | 1 | Read request for word `mem_rd_addr` |
| mem_rd_addr | output | ADDR_W | Word address of the read |
| mem_rsp_valid | input | 1 | Read data valid (responses in request order) |
| mem_rsp_data | input | 32*LANES | Returned word of seeds |
| mem_wr_valid | output | 1 | Write request |
| mem_wr_addr | output | ADDR_W | Word address of the write |
| mem_wr_data | output | 32*LANES | Result word |
| mem_wr_be | output | 4*LANES | Byte enables |

## Verification
The bench uses the default build: 8 lanes, 20 items and 5 steps. With these values the batch takes three memory words, and the last word has only four live lanes. That tail word exercises byte masking, because the bench fills the dead lanes with sentinel values and expects them to survive. The first run uses seeds 0 through 19, which covers the zero seed and seeds 1 to 7, and returns read data back to back. This shows single-cycle throughput and the exact write latency. The second run uses extreme seeds such as all-ones and a lone top bit, returns data only on alternate cycles, and repeats `start` while the batch is in progress.

// File: rtl/lcg_pkg.sv
package lcg_pkg;

    localparam int SEED_W  = 32;
    localparam int STATE_W = 48;

    localparam logic [STATE_W-1:0] LCG_MUL = 48'h0005_DEEC_E66D;
    localparam logic [STATE_W-1:0] LCG_INC = 48'h0000_0000_000B;
    localparam logic [15:0]        LCG_LOW = 16'h330E;

    typedef logic [STATE_W-1:0] lcg_state_t;

    typedef enum logic {
        CTRL_IDLE = 1'b0,
        CTRL_RUN  = 1'b1
    } ctrl_state_e;

    // Loads a seed into the upper bits and places the fixed constant below it.
    function automatic lcg_state_t seed_to_state(input logic [SEED_W-1:0] seed);
        return {seed, LCG_LOW};
    endfunction

    // Performs one recurrence step. The 48-bit result width drops the carry past bit 47.
    function automatic lcg_state_t lcg_step(input lcg_state_t x);
        return x * LCG_MUL + LCG_INC;
    endfunction

    // Takes the top 31 state bits and clears bit 31 of the result.
    function automatic logic [SEED_W-1:0] state_to_word(input lcg_state_t x);
        return {1'b0, x[STATE_W-1:17]};
    endfunction

endpackage

// File: rtl/lcg_lane_pipe.sv
module lcg_lane_pipe
    import lcg_pkg::*;
#(
    parameter int N_STEPS = 5
) (
    input  logic              clk,
    input  logic [SEED_W-1:0] in_seed,
    output logic [SEED_W-1:0] out_word
);

    // Stage 0 holds the seeded state. Stage j holds that state after j steps.
    lcg_state_t st_q [N_STEPS+1];

    always_ff @(posedge clk) begin
        st_q[0] <= seed_to_state(in_seed);
        for (int j = 1; j <= N_STEPS; j++) begin
            st_q[j] <= lcg_step(st_q[j-1]);
        end
    end

    assign out_word = state_to_word(st_q[N_STEPS]);

endmodule

// File: rtl/lcg_tag_delay.sv
module lcg_tag_delay #(
    parameter int DEPTH = 6,
    parameter int TAG_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [TAG_W-1:0] in_tag,
    output logic             out_valid,
    output logic [TAG_W-1:0] out_tag
);

    logic [DEPTH-1:0] v_q;
    logic [TAG_W-1:0] t_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) v_q <= '0;
        else     v_q <= {v_q[DEPTH-2:0], in_valid};
    end

    always_ff @(posedge clk) begin
        t_q[0] <= in_tag;
        for (int k = 1; k < DEPTH; k++) begin
            t_q[k] <= t_q[k-1];
        end
    end

    assign out_valid = v_q[DEPTH-1];
    assign out_tag   = t_q[DEPTH-1];

endmodule

// File: rtl/lcg_batch_ctrl.sv
module lcg_batch_ctrl
    import lcg_pkg::*;
#(
    parameter int N_WORDS = 3,
    parameter int ADDR_W  = 2,
    localparam int CNT_W  = $clog2(N_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              rsp_valid,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [ADDR_W-1:0] rsp_tag,
    output logic              done
);

    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(N_WORDS - 1);

    ctrl_state_e       state_q;
    logic              rd_valid_q;
    logic [ADDR_W-1:0] rd_idx_q;
    logic [CNT_W-1:0]  rd_issued_q;
    logic [ADDR_W-1:0] rsp_cnt_q;
    logic [ADDR_W-1:0] wr_cnt_q;
    logic              done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= CTRL_IDLE;
            rd_valid_q  <= 1'b0;
            rd_idx_q    <= '0;
            rd_issued_q <= '0;
            rsp_cnt_q   <= '0;
            wr_cnt_q    <= '0;
            done_q      <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (state_q == CTRL_IDLE) begin
                if (start) begin
                    state_q     <= CTRL_RUN;
                    rd_valid_q  <= 1'b1;
                    rd_idx_q    <= '0;
                    rd_issued_q <= '0;
                    rsp_cnt_q   <= '0;
                    wr_cnt_q    <= '0;
                end
            end else begin
                if (rd_valid_q) begin
                    rd_issued_q <= rd_issued_q + 1'b1;
                    if (rd_idx_q == LAST) rd_valid_q <= 1'b0;
                    else                  rd_idx_q   <= rd_idx_q + 1'b1;
                end
                if (rsp_valid) rsp_cnt_q <= rsp_cnt_q + 1'b1;
                if (wr_valid) begin
                    wr_cnt_q <= wr_cnt_q + 1'b1;
                    if (wr_cnt_q == LAST) begin
                        done_q  <= 1'b1;
                        state_q <= CTRL_IDLE;
                    end
                end
            end
        end
    end

    assign rd_valid = rd_valid_q;
    assign rd_addr  = rd_idx_q;
    assign rsp_tag  = rsp_cnt_q;
    assign done     = done_q;

    // R5: consecutive reads step through ascending addresses
    p_rd_seq_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_valid_q && rd_idx_q != LAST) |=> (rd_valid_q && rd_idx_q == ADDR_W'($past(rd_idx_q) + 1'b1)));

    // R9: no read is issued while idle
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q == CTRL_IDLE) |-> !rd_valid_q);

    // R6: a response never arrives before its request has been issued
    p_rsp_bound_r6: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (CNT_W'(rsp_cnt_q) < rd_issued_q));

    // R4: the pipeline's write tags come out in ascending word order
    p_wr_order_r4: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> (wr_addr == wr_cnt_q));

    // R8: done lasts a single cycle
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R8: done comes right after a write
    p_done_after_wr_r8: assert property (@(posedge clk) disable iff (rst)
        done_q |-> $past(wr_valid));

endmodule

// File: rtl/lcg_batch_engine.sv
module lcg_batch_engine
    import lcg_pkg::*;
#(
    parameter int LANES   = 8,
    parameter int N_ITEMS = 20,
    parameter int N_STEPS = 5,
    localparam int N_WORDS = (N_ITEMS + LANES - 1) / LANES,
    localparam int ADDR_W  = (N_WORDS > 1) ? $clog2(N_WORDS) : 1,
    localparam int MEM_W   = LANES * SEED_W,
    localparam int BE_W    = MEM_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              done,
    output logic              mem_rd_valid,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rsp_valid,
    input  logic [MEM_W-1:0]  mem_rsp_data,
    output logic              mem_wr_valid,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [MEM_W-1:0]  mem_wr_data,
    output logic [BE_W-1:0]   mem_wr_be
);

    localparam int LANE_BYTES = SEED_W / 8;

    logic [ADDR_W-1:0] rsp_tag;

    lcg_batch_ctrl #(
        .N_WORDS (N_WORDS),
        .ADDR_W  (ADDR_W)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .rsp_valid (mem_rsp_valid),
        .wr_valid  (mem_wr_valid),
        .wr_addr   (mem_wr_addr),
        .rd_valid  (mem_rd_valid),
        .rd_addr   (mem_rd_addr),
        .rsp_tag   (rsp_tag),
        .done      (done)
    );

    // The valid flag and word address travel alongside the lane data, one stage per data stage.
    lcg_tag_delay #(
        .DEPTH (N_STEPS + 1),
        .TAG_W (ADDR_W)
    ) u_tag (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (mem_rsp_valid),
        .in_tag    (rsp_tag),
        .out_valid (mem_wr_valid),
        .out_tag   (mem_wr_addr)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        lcg_lane_pipe #(
            .N_STEPS (N_STEPS)
        ) u_lane (
            .clk      (clk),
            .in_seed  (mem_rsp_data[l*SEED_W +: SEED_W]),
            .out_word (mem_wr_data[l*SEED_W +: SEED_W])
        );

        // A lane whose item index is past the end of the batch is not written.
        assign mem_wr_be[l*LANE_BYTES +: LANE_BYTES] =
            ((int'(mem_wr_addr) * LANES + l) < N_ITEMS) ? {LANE_BYTES{1'b1}} : {LANE_BYTES{1'b0}};
    end

endmodule

// File: tb/lcg_batch_engine_tb.sv
module lcg_batch_engine_tb;

    localparam int LANES   = 8;
    localparam int N_ITEMS = 20;
    localparam int N_STEPS = 5;
    localparam int N_WORDS = (N_ITEMS + LANES - 1) / LANES;
    localparam int ADDR_W  = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;
    localparam int MEM_W   = LANES * 32;
    localparam int BE_W    = MEM_W / 8;
    localparam int N_SLOTS = N_WORDS * LANES;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic done;
    logic mem_rd_valid;
    logic [ADDR_W-1:0] mem_rd_addr;
    logic mem_rsp_valid = 1'b0;
    logic [MEM_W-1:0] mem_rsp_data = '0;
    logic mem_wr_valid;
    logic [ADDR_W-1:0] mem_wr_addr;
    logic [MEM_W-1:0] mem_wr_data;
    logic [BE_W-1:0] mem_wr_be;

    always #2 clk = ~clk;

    lcg_batch_engine #(
        .LANES   (LANES),
        .N_ITEMS (N_ITEMS),
        .N_STEPS (N_STEPS)
    ) u_dut (
        .clk           (clk),
        .rst           (rst),
        .start         (start),
        .done          (done),
        .mem_rd_valid  (mem_rd_valid),
        .mem_rd_addr   (mem_rd_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .mem_wr_valid  (mem_wr_valid),
        .mem_wr_addr   (mem_wr_addr),
        .mem_wr_data   (mem_wr_data),
        .mem_wr_be     (mem_wr_be)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic [MEM_W-1:0] mem [N_WORDS];
    logic [31:0] seeds [N_SLOTS];

    logic [MEM_W-1:0] rsp_q[$];
    int               exp_cyc[$];
    int               exp_addr[$];
    logic [MEM_W-1:0] exp_seed[$];

    bit stall_mode = 1'b0;
    int next_rd = 0, rd_seen = 0, wr_seen = 0, done_seen = 0;
    int rsp_idx = 0, last_wr_cyc = -10;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_out(input logic [31:0] seed, input int n);
        logic [63:0] s;
        s = {16'h0, seed, 16'h330E};
        for (int k = 0; k < n; k++) s = (s * 64'h5_DEEC_E66D + 64'hB) & 64'h0000_FFFF_FFFF_FFFF;
        return {1'b0, s[47:17]};
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            errors++;
            checks++;
            $display("FAIL R8 watchdog: actual %0d expected done before 20000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Memory model and per-cycle reference comparison
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_wr_valid) begin
                if (exp_cyc.size() == 0) begin
                    chk(1'b0, "R6", "unexpected write", 64'(mem_wr_addr), 64'hFFFF);
                end else begin
                    int ec, ea;
                    logic [MEM_W-1:0] es;
                    ec = exp_cyc.pop_front();
                    ea = exp_addr.pop_front();
                    es = exp_seed.pop_front();
                    chk(cyc == ec, "R6", "write cycle", 64'(cyc), 64'(ec));
                    chk(int'(mem_wr_addr) == ea, "R4", "write address", 64'(mem_wr_addr), 64'(ea));
                    for (int l = 0; l < LANES; l++) begin
                        bit live;
                        live = (ea * LANES + l) < N_ITEMS;
                        chk(mem_wr_be[l*4 +: 4] == (live ? 4'hF : 4'h0), "R7", "lane byte enables",
                            64'(mem_wr_be[l*4 +: 4]), live ? 64'hF : 64'h0);
                        if (live)
                            chk(mem_wr_data[l*32 +: 32] == ref_out(es[l*32 +: 32], N_STEPS), "R3",
                                "lane result", 64'(mem_wr_data[l*32 +: 32]), 64'(ref_out(es[l*32 +: 32], N_STEPS)));
                    end
                end
                for (int b = 0; b < BE_W; b++)
                    if (mem_wr_be[b]) mem[mem_wr_addr][b*8 +: 8] = mem_wr_data[b*8 +: 8];
                wr_seen++;
                last_wr_cyc = cyc;
            end
            if (done) begin
                done_seen++;
                chk(cyc == last_wr_cyc + 1, "R8", "done timing", 64'(cyc), 64'(last_wr_cyc + 1));
            end
            // Respond first, so that a read is never answered in the cycle it is issued.
            mem_rsp_valid = 1'b0;
            if (rsp_q.size() > 0 && (!stall_mode || (cyc % 2 == 0))) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = rsp_q.pop_front();
                exp_cyc.push_back(cyc + N_STEPS + 1);
                exp_addr.push_back(rsp_idx);
                exp_seed.push_back(mem_rsp_data);
                rsp_idx++;
            end
            if (mem_rd_valid) begin
                chk(int'(mem_rd_addr) == next_rd, "R5", "read address", 64'(mem_rd_addr), 64'(next_rd));
                rsp_q.push_back(mem[mem_rd_addr]);
                next_rd++;
                rd_seen++;
            end
        end
    end

    task automatic load_batch(input int variant);
        for (int i = 0; i < N_SLOTS; i++) begin
            if (i >= N_ITEMS)  seeds[i] = 32'hA5A5_0000 + 32'(i);
            else if (variant == 0) seeds[i] = 32'(i);
            else if (i == 0)   seeds[i] = 32'hFFFF_FFFF;
            else if (i == 1)   seeds[i] = 32'h8000_0000;
            else               seeds[i] = 32'(i) * 32'h9E37_79B9 ^ 32'h5A5A_1234;
        end
        for (int w = 0; w < N_WORDS; w++)
            for (int l = 0; l < LANES; l++) mem[w][l*32 +: 32] = seeds[w*LANES + l];
    endtask

    task automatic run_batch(input bit stall, input string tag);
        stall_mode = stall;
        next_rd = 0; rd_seen = 0; wr_seen = 0; done_seen = 0; rsp_idx = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(mem_rd_valid == 1'b1, "R5", {tag, " read begins after start"}, 64'(mem_rd_valid), 64'h1);
        @(negedge clk);
        @(negedge clk); start = 1'b1;   // R9: a second start while busy
        @(negedge clk); start = 1'b0;
        for (int t = 0; t < 200 && done_seen == 0; t++) @(negedge clk);
        for (int t = 0; t < 15; t++) @(negedge clk);
        chk(rd_seen == N_WORDS, "R9", {tag, " read count"}, 64'(rd_seen), 64'(N_WORDS));
        chk(wr_seen == N_WORDS, "R9", {tag, " write count"}, 64'(wr_seen), 64'(N_WORDS));
        chk(done_seen == 1, "R8", {tag, " done pulses"}, 64'(done_seen), 64'h1);
        chk(exp_cyc.size() == 0, "R6", {tag, " outstanding writes"}, 64'(exp_cyc.size()), 64'h0);
        for (int i = 0; i < N_SLOTS; i++) begin
            logic [31:0] got, want;
            got  = mem[i / LANES][(i % LANES)*32 +: 32];
            want = (i < N_ITEMS) ? ref_out(seeds[i], N_STEPS) : seeds[i];
            if (i < N_ITEMS) chk(got == want, "R1", $sformatf("%s item %0d in place (R2 R3 R4)", tag, i), 64'(got), 64'(want));
            else             chk(got == want, "R7", $sformatf("%s slot %0d untouched", tag, i), 64'(got), 64'(want));
        end
    endtask

    initial begin
        load_batch(0);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(mem_rd_valid == 1'b0, "R10", "reset read valid", 64'(mem_rd_valid), 64'h0);
        chk(mem_wr_valid == 1'b0, "R10", "reset write valid", 64'(mem_wr_valid), 64'h0);
        chk(done == 1'b0, "R10", "reset done", 64'(done), 64'h0);

        // R1: seed zero starts from state 0x330E, so one step gives a known constant
        chk(ref_out(32'h0, 1) == 32'(((64'h330E * 64'h5DEECE66D + 64'hB) & 64'hFFFF_FFFF_FFFF) >> 17),
            "R1", "reference self-test", 64'(ref_out(32'h0, 1)), 64'h0);

        run_batch(1'b0, "back-to-back");
        load_batch(1);
        run_batch(1'b1, "stalled");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule